// File: doc/BRIEF.md
# Output-Gated Scan Chain

This block is a chain of multiplexed-input scan flip-flops that sits around a piece of combinational logic. In normal operation every cell captures its own bit of a parallel functional input on each clock edge. With scan enable high, the cells form a shift register: the first cell takes the serial scan input, each later cell takes its upstream neighbour, and the last cell drives the scan output.

Each cell also drives one bit of a parallel bus into the logic under test. In the low-power variant, selected by a parameter, that bus is frozen while scan enable is high. The logic therefore sees no intermediate patterns while a new state ripples through the chain. When scan enable drops, the bus shows the shifted contents at once. In the plain variant the bus simply follows the flip-flops. A built-in counter adds up the number of bus bits that change between consecutive clock edges, so the switching activity of the two variants can be compared.

Top module: `lowpwr_scan_chain`

## Requirements
- R1: While reset is asserted, all cell flip-flops, all held outputs, the logic-side bus, the scan output and the toggle count are 0.
- R2: With scan enable low, one rising edge loads every bit of the functional input into its cell. After that same edge the logic-side bus equals the new value in both variants.
- R3: With scan enable high, each rising edge loads the scan input into cell 0 and loads cell i-1 into cell i. The functional input has no effect on the cells, as seen on the plain bus.
- R4: The scan output is the flip-flop of the last cell. A bit presented on the scan input appears on the scan output after CHAIN_LEN shift edges.
- R5: In the low-power variant, the logic-side bus keeps the value it had before the first shift edge for as long as scan enable stays high.
- R6: In the low-power variant, when scan enable goes low the logic-side bus shows the current flip-flop contents within the same cycle, before the next edge.
- R7: In the plain variant, the logic-side bus equals the flip-flop contents in every cycle, including during shift.
- R8: On each rising edge the toggle count grows by the number of logic-side bus bits that differ between this edge and the previous edge.
- R9: For a 3-cell chain holding 100 (cell 0 first) that shifts in the state 010, the plain variant counts 2, then 3, then 3 changes, 8 in total. The low-power variant counts no change during the shift and 2 changes at release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| scanEn | input | 1 | 1 = shift through the chain, 0 = capture the functional input |
| scanIn | input | 1 | Serial input to cell 0 |
| funcD | input | CHAIN_LEN | Functional capture data, bit i goes to cell i |
| logicOut | output | CHAIN_LEN | Bus driven into the combinational logic, bit i from cell i |
| scanOut | output | 1 | Serial output, the last cell's flip-flop |
| toggleCnt | output | CNT_W | Running total of logic-side bus bit changes |

## Verification
Two events can fall in the same cycle. The release of the frozen bus happens as soon as scan enable falls. The functional capture happens at the following edge. During that one cycle the bus shows the shifted state, and after the edge it shows new captured data. The bench drops scan enable while driving a different functional word, samples the bus before the edge to see the shifted state, and samples again after the edge to see the captured word. The toggle count is checked after that same edge: it must include the release change and must not yet include the capture change. A gated and an ungated instance run side by side with identical stimulus, so that their counts can be compared.

// File: rtl/scan_chain_pkg.sv
package scan_chain_pkg;

  // Strobes from the control decode to the cell datapath
  typedef struct packed {
    logic shiftSel;   // mux select: 1 = serial neighbour, 0 = functional bit
    logic holdOut;    // present held copy on the logic-side bus
    logic loadHold;   // refresh the held copy with the captured value
  } scanStrobe_t;

  function automatic int unsigned countOnes(input logic [63:0] vec, input int unsigned width);
    int unsigned total;
    total = 0;
    for (int unsigned k = 0; k < width; k++) begin
      total += vec[k];
    end
    return total;
  endfunction

endpackage

// File: rtl/scan_chain_ctrl.sv
module scan_chain_ctrl
  import scan_chain_pkg::*;
#(
  parameter bit LOW_POWER = 1'b1
) (
  input  logic        scanEn,
  output scanStrobe_t strobe
);

  always_comb begin
    strobe.shiftSel = scanEn;
    strobe.loadHold = ~scanEn;
  end

  generate
    if (LOW_POWER) begin : g_gated
      always_comb strobe.holdOut = scanEn;
    end else begin : g_plain
      always_comb strobe.holdOut = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/scan_chain_datapath.sv
module scan_chain_datapath
  import scan_chain_pkg::*;
#(
  parameter int CHAIN_LEN = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scanStrobe_t          strobe,
  input  logic                 scanIn,
  input  logic [CHAIN_LEN-1:0] funcD,
  output logic [CHAIN_LEN-1:0] logicOut,
  output logic                 scanOut
);

  localparam int LAST = CHAIN_LEN - 1;

  logic [CHAIN_LEN-1:0] ffQ;
  logic [CHAIN_LEN-1:0] ffNext;
  logic [CHAIN_LEN-1:0] heldQ;
  logic [CHAIN_LEN-1:0] serialIn;

  generate
    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
      if (i == 0) begin : g_head
        assign serialIn[i] = scanIn;
      end else begin : g_link
        assign serialIn[i] = ffQ[i-1];
      end

      assign ffNext[i] = strobe.shiftSel ? serialIn[i] : funcD[i];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ffQ[i]   <= 1'b0;
          heldQ[i] <= 1'b0;
        end else begin
          ffQ[i] <= ffNext[i];
          if (strobe.loadHold) heldQ[i] <= ffNext[i];
        end
      end

      assign logicOut[i] = strobe.holdOut ? heldQ[i] : ffQ[i];

      if (i > 0) begin : g_link_chk
        // R3
        shift_link_chk: assert property (@(posedge clk) disable iff (!rstN)
          strobe.shiftSel |=> ffQ[i] == $past(ffQ[i-1]));
      end
    end
  endgenerate

  assign scanOut = ffQ[LAST];

  // R3
  shift_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftSel |=> ffQ[0] == $past(scanIn));

  // R2
  capture_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftSel |=> ffQ == $past(funcD));

  // R5
  frozen_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.holdOut && $past(strobe.holdOut)) |-> $stable(logicOut));

endmodule

// File: rtl/toggle_counter.sv
module toggle_counter
  import scan_chain_pkg::*;
#(
  parameter int WIDTH = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] busVal,
  output logic [CNT_W-1:0] count
);

  logic [WIDTH-1:0] prevQ;
  logic [63:0]      diffVec;
  logic [CNT_W-1:0] stepVal;

  always_comb begin
    diffVec = '0;
    diffVec[WIDTH-1:0] = busVal ^ prevQ;
    stepVal = CNT_W'(countOnes(diffVec, WIDTH));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= '0;
      count <= '0;
    end else begin
      prevQ <= busVal;
      count <= count + stepVal;
    end
  end

  // R8
  step_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (count - $past(count)) <= CNT_W'(WIDTH));

endmodule

// File: rtl/lowpwr_scan_chain.sv
module lowpwr_scan_chain
  import scan_chain_pkg::*;
#(
  parameter int CHAIN_LEN = 3,
  parameter bit LOW_POWER = 1'b1,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 scanEn,
  input  logic                 scanIn,
  input  logic [CHAIN_LEN-1:0] funcD,
  output logic [CHAIN_LEN-1:0] logicOut,
  output logic                 scanOut,
  output logic [CNT_W-1:0]     toggleCnt
);

  scanStrobe_t strobe;

  scan_chain_ctrl #(.LOW_POWER(LOW_POWER)) u_ctrl (
    .scanEn (scanEn),
    .strobe (strobe)
  );

  scan_chain_datapath #(.CHAIN_LEN(CHAIN_LEN)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .scanIn   (scanIn),
    .funcD    (funcD),
    .logicOut (logicOut),
    .scanOut  (scanOut)
  );

  toggle_counter #(.WIDTH(CHAIN_LEN), .CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rstN   (rstN),
    .busVal (logicOut),
    .count  (toggleCnt)
  );

endmodule

// File: tb/lowpwr_scan_chain_bench.sv
module lowpwr_scan_chain_bench;
  localparam int N  = 3;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, scanEn, scanIn;
  logic [N-1:0]  funcD;
  logic [N-1:0]  gOut, pOut;
  logic          gSo, pSo;
  logic [CW-1:0] gCnt, pCnt;

  lowpwr_scan_chain #(.CHAIN_LEN(N), .LOW_POWER(1'b1), .CNT_W(CW)) u_lowpwr_scan_chain (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .scanIn(scanIn), .funcD(funcD),
    .logicOut(gOut), .scanOut(gSo), .toggleCnt(gCnt));

  lowpwr_scan_chain #(.CHAIN_LEN(N), .LOW_POWER(1'b0), .CNT_W(CW)) u_lowpwr_scan_chain_plain (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .scanIn(scanIn), .funcD(funcD),
    .logicOut(pOut), .scanOut(pSo), .toggleCnt(pCnt));

  typedef struct {
    logic [N-1:0] expG;
    logic [N-1:0] expP;
    logic         expSo;
    string        req;
  } expItem_t;

  expItem_t sbQ[$];
  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: set inputs at the falling edge, queue what must appear after the next rising edge
  task automatic apply(input logic se, input logic si, input logic [N-1:0] d,
                       input logic [N-1:0] eg, input logic [N-1:0] ep, input logic eso, input string req);
    expItem_t it;
    @(negedge clk);
    scanEn = se; scanIn = si; funcD = d;
    it.expG = eg; it.expP = ep; it.expSo = eso; it.req = req;
    sbQ.push_back(it);
  endtask

  task automatic cntAt(input int eg, input int ep, input string req);
    @(posedge clk); #2;
    chk(req, "gated toggle count", 32'(gCnt), 32'(eg));
    chk(req, "plain toggle count", 32'(pCnt), 32'(ep));
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk); #2;
      if (sbQ.size() > 0) begin
        expItem_t it;
        it = sbQ.pop_front();
        chk(it.req, "gated bus", 32'(gOut), 32'(it.expG));
        chk(it.req, "plain bus", 32'(pOut), 32'(it.expP));
        chk(it.req, "gated scanOut", 32'(gSo), 32'(it.expSo));
        chk(it.req, "plain scanOut", 32'(pSo), 32'(it.expSo));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; scanEn = 1'b0; scanIn = 1'b0; funcD = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "gated bus", 32'(gOut), 0);
    chk("R1", "plain bus", 32'(pOut), 0);
    chk("R1", "gated scanOut", 32'(gSo), 0);
    chk("R1", "plain scanOut", 32'(pSo), 0);
    chk("R1", "gated count", 32'(gCnt), 0);
    chk("R1", "plain count", 32'(pCnt), 0);
    rstN = 1'b1;

    // R2 capture state 100 (cell 0 first)
    apply(1'b0, 1'b0, 3'b001, 3'b001, 3'b001, 1'b0, "R2");
    apply(1'b0, 1'b0, 3'b001, 3'b001, 3'b001, 1'b0, "R2");
    cntAt(1, 1, "R8");

    // R9 shift 010 in: cell states 010, 101, 010
    apply(1'b1, 1'b0, 3'b111, 3'b001, 3'b010, 1'b0, "R5");
    apply(1'b1, 1'b1, 3'b000, 3'b001, 3'b101, 1'b1, "R7");
    apply(1'b1, 1'b0, 3'b111, 3'b001, 3'b010, 1'b0, "R3");
    cntAt(1, 6, "R9");

    // release and capture in the same cycle
    apply(1'b0, 1'b0, 3'b110, 3'b110, 3'b110, 1'b1, "R2");
    #1 chk("R6", "gated bus on release", 32'(gOut), 32'(3'b010));
    cntAt(3, 9, "R9");

    // R3 R4 longer shift with functional input toggling
    apply(1'b1, 1'b1, 3'b111, 3'b110, 3'b101, 1'b1, "R3");
    apply(1'b1, 1'b0, 3'b000, 3'b110, 3'b010, 1'b0, "R4");
    apply(1'b1, 1'b1, 3'b111, 3'b110, 3'b101, 1'b1, "R4");
    apply(1'b1, 1'b1, 3'b101, 3'b110, 3'b011, 1'b0, "R4");
    apply(1'b0, 1'b0, 3'b000, 3'b000, 3'b000, 1'b0, "R2");

    repeat (3) @(posedge clk);
    #3;
    chk("R2", "scoreboard drained", 32'(sbQ.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule